// File: doc/BRIEF.md
# Debug Port Security Lock

This block sits between the in-circuit debug port of a microcontroller and its on-chip flash, and decides for each debug command whether it may proceed. After a power-on reset the port is open. Boot code that runs in the preboot interval, before the main boot sequence, may write a security-enable strobe. Once the lock is set, the only command that passes is a global flash erase. Every other command is refused and flagged with a violation pulse.

The lock survives chip resets. The only way to open it again is for a global flash erase to complete and then for a chip reset to arrive. The erase is remembered in an internal flag that the next chip reset consumes. A chip reset with no erase before it leaves the lock set. A new lock write discards any erase that was recorded before it. The power-on reset `rst_n` is the only other way to clear the state.

Top module: `dbg_sec_lock`

## Requirements
- R1: While `rst_n` is low at a clock edge, the lock is cleared and no erase is recorded. After that edge `locked_o` is 0 and `dbg_viol_o` is 0.
- R2: A `sec_en_wr_i` strobe sampled with `preboot_i` high and `chip_rst_i` low sets `locked_o` from the next cycle.
- R3: A `sec_en_wr_i` strobe sampled with `preboot_i` low is ignored, and `locked_o` stays 0.
- R4: While locked, a valid command whose code equals the erase-all code (default 3'b111 on a 3-bit `dbg_cmd_i`) is granted in the same cycle.
- R5: While locked, a valid command with any other code is not granted. `dbg_viol_o` is high in the next cycle, and it stays high only for as long as blocked commands keep arriving.
- R6: While unlocked, every valid command code is granted and `dbg_viol_o` stays 0.
- R7: A chip reset with no global erase recorded since the last chip reset or lock write leaves `locked_o` at 1.
- R8: An `erase_done_i` pulse followed in a later cycle by a `chip_rst_i` pulse clears `locked_o` from the cycle after the reset. The erase on its own does not clear the lock.
- R9: A chip reset clears the recorded erase. A lock that is set after that reset therefore survives the next chip reset.
- R10: An `erase_done_i` pulse in the same cycle as `chip_rst_i` is not recorded.
- R11: A lock write discards an erase that was recorded before it.
- R12: A lock write in the same cycle as `chip_rst_i` is ignored, even with `preboot_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low; clears all state |
| chip_rst_i | input | 1 | Chip (warm) reset event, one cycle per reset |
| preboot_i | input | 1 | High while preboot code is running |
| sec_en_wr_i | input | 1 | CPU strobe requesting security enable |
| dbg_valid_i | input | 1 | A debug command is presented this cycle |
| dbg_cmd_i | input | CMD_W | Command type code |
| erase_done_i | input | 1 | Global flash erase completed (one-cycle pulse) |
| dbg_grant_o | output | 1 | Presented command may proceed |
| dbg_viol_o | output | 1 | A command was blocked in the previous cycle |
| locked_o | output | 1 | Current lock state |

## Verification
The assertions assume that `chip_rst_i` and `erase_done_i` are single-cycle events. They also assume that `dbg_cmd_i` only matters in cycles where `dbg_valid_i` is high. The bench drives every event as a one-cycle pulse, changing inputs only on the falling edge. It sweeps all eight command codes in both the locked and the unlocked state. The erase, reset and lock-write events are applied in every ordering the requirements name, including the same-cycle collisions.

// File: rtl/dbg_sec_lock_pkg.sv
// Shared types for the debug port security lock.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package dbg_sec_lock_pkg;

    typedef enum logic {
        LK_OPEN    = 1'b0,
        LK_SECURED = 1'b1
    } lock_state_t;

    typedef struct packed {
        logic grant;
        logic block;
    } dbg_verdict_t;

endpackage

// File: rtl/dbg_sec_lock_state.sv
// Holds the sticky lock state and the recorded global-erase flag.
// Assumes: chip_rst_i and erase_done_i are single-cycle events; rst_n is
// the power-on reset and is the only thing that clears the lock unconditionally.
module dbg_sec_lock_state
    import dbg_sec_lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        chip_rst_i,
    input  logic        preboot_i,
    input  logic        sec_en_wr_i,
    input  logic        erase_done_i,
    output lock_state_t state_o,
    output logic        erased_o
);

    lock_state_t state_q;
    logic        erased_q;
    logic        set_req;

    // Lock requests count only inside the preboot window.
    always_comb begin
        set_req = sec_en_wr_i && preboot_i;
    end

    // Update the lock and erase flag; chip reset takes precedence over all events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= LK_OPEN;
            erased_q <= 1'b0;
        end else if (chip_rst_i) begin
            if (erased_q) begin
                state_q <= LK_OPEN;
            end
            erased_q <= 1'b0;
        end else if (set_req) begin
            state_q  <= LK_SECURED;
            erased_q <= 1'b0;
        end else if (erase_done_i) begin
            erased_q <= 1'b1;
        end
    end

    assign state_o  = state_q;
    assign erased_o = erased_q;

endmodule

// File: rtl/dbg_sec_lock_gate.sv
// Decides per debug command whether it proceeds and registers a violation pulse.
// Assumes: dbg_cmd_i is meaningful only while dbg_valid_i is high.
module dbg_sec_lock_gate
    import dbg_sec_lock_pkg::*;
#(
    parameter int                CMD_W      = 3,
    parameter logic [CMD_W-1:0]  ERASE_CODE = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lock_state_t      state_i,
    input  logic             dbg_valid_i,
    input  logic [CMD_W-1:0] dbg_cmd_i,
    output logic             dbg_grant_o,
    output logic             dbg_viol_o
);

    dbg_verdict_t verdict;
    logic         is_erase_all;
    logic         viol_q;

    // Classify the command and form the allow/block verdict.
    always_comb begin
        is_erase_all  = (dbg_cmd_i == ERASE_CODE);
        verdict.grant = dbg_valid_i && ((state_i == LK_OPEN) || is_erase_all);
        verdict.block = dbg_valid_i && (state_i == LK_SECURED) && !is_erase_all;
    end

    // Register one violation pulse per blocked command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_q <= 1'b0;
        end else begin
            viol_q <= verdict.block;
        end
    end

    assign dbg_grant_o = verdict.grant;
    assign dbg_viol_o  = viol_q;

endmodule

// File: rtl/dbg_sec_lock.sv
// Top of the debug port security lock: sticky lock state plus command gate.
// Assumes: synchronous active-low power-on reset; chip_rst_i is a warm reset
// event that the lock must survive unless a global erase came before it.
module dbg_sec_lock
    import dbg_sec_lock_pkg::*;
#(
    parameter int               CMD_W      = 3,
    parameter logic [CMD_W-1:0] ERASE_CODE = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_rst_i,
    input  logic             preboot_i,
    input  logic             sec_en_wr_i,
    input  logic             dbg_valid_i,
    input  logic [CMD_W-1:0] dbg_cmd_i,
    input  logic             erase_done_i,
    output logic             dbg_grant_o,
    output logic             dbg_viol_o,
    output logic             locked_o
);

    lock_state_t state_w;
    logic        erased_w;

    dbg_sec_lock_state u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .chip_rst_i   (chip_rst_i),
        .preboot_i    (preboot_i),
        .sec_en_wr_i  (sec_en_wr_i),
        .erase_done_i (erase_done_i),
        .state_o      (state_w),
        .erased_o     (erased_w)
    );

    dbg_sec_lock_gate #(
        .CMD_W      (CMD_W),
        .ERASE_CODE (ERASE_CODE)
    ) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_i     (state_w),
        .dbg_valid_i (dbg_valid_i),
        .dbg_cmd_i   (dbg_cmd_i),
        .dbg_grant_o (dbg_grant_o),
        .dbg_viol_o  (dbg_viol_o)
    );

    assign locked_o = (state_w == LK_SECURED);

endmodule

// File: rtl/dbg_sec_lock_chk.sv
// Checker for the debug port security lock, bound to the top module.
// Assumes: single-cycle chip reset and erase events.
module dbg_sec_lock_chk #(
    parameter int               CMD_W      = 3,
    parameter logic [CMD_W-1:0] ERASE_CODE = '1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chip_rst_i,
    input logic             preboot_i,
    input logic             sec_en_wr_i,
    input logic             dbg_valid_i,
    input logic [CMD_W-1:0] dbg_cmd_i,
    input logic             erase_done_i,
    input logic             dbg_grant_o,
    input logic             dbg_viol_o,
    input logic             locked_o,
    input logic             erased
);

    a_r2_rise_needs_preboot_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(sec_en_wr_i && preboot_i && !chip_rst_i));

    a_r4_erase_all_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_valid_i && locked_o && dbg_cmd_i == ERASE_CODE) |-> dbg_grant_o);

    a_r5_other_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_valid_i && locked_o && dbg_cmd_i != ERASE_CODE) |-> !dbg_grant_o);

    a_r5_viol_follows_block: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_valid_i && locked_o && dbg_cmd_i != ERASE_CODE) |=> dbg_viol_o);

    a_r5_viol_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_viol_o && $past(rst_n)) |-> $past(dbg_valid_i && locked_o && dbg_cmd_i != ERASE_CODE));

    a_r6_open_grants: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_valid_i && !locked_o) |-> dbg_grant_o);

    a_r7_reset_without_erase_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_rst_i && locked_o && !erased) |=> locked_o);

    a_r8_fall_needs_chip_reset: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(locked_o) && $past(rst_n)) |-> $past(chip_rst_i && erased));

    a_r9_reset_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_i |=> !erased);

endmodule

bind dbg_sec_lock dbg_sec_lock_chk #(
    .CMD_W      (CMD_W),
    .ERASE_CODE (ERASE_CODE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .chip_rst_i   (chip_rst_i),
    .preboot_i    (preboot_i),
    .sec_en_wr_i  (sec_en_wr_i),
    .dbg_valid_i  (dbg_valid_i),
    .dbg_cmd_i    (dbg_cmd_i),
    .erase_done_i (erase_done_i),
    .dbg_grant_o  (dbg_grant_o),
    .dbg_viol_o   (dbg_viol_o),
    .locked_o     (locked_o),
    .erased       (erased_w)
);

// File: tb/dbg_sec_lock_test.sv
// Bench: sweeps all command codes in both lock states and walks every
// erase / reset / lock-write ordering. Inputs change on the falling edge.
module dbg_sec_lock_test;

    localparam int CMD_W = 3;
    localparam int ERASE = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             chip_rst_i = 1'b0;
    logic             preboot_i = 1'b0;
    logic             sec_en_wr_i = 1'b0;
    logic             dbg_valid_i = 1'b0;
    logic [CMD_W-1:0] dbg_cmd_i = '0;
    logic             erase_done_i = 1'b0;
    logic             dbg_grant_o;
    logic             dbg_viol_o;
    logic             locked_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    dbg_sec_lock uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .chip_rst_i   (chip_rst_i),
        .preboot_i    (preboot_i),
        .sec_en_wr_i  (sec_en_wr_i),
        .dbg_valid_i  (dbg_valid_i),
        .dbg_cmd_i    (dbg_cmd_i),
        .erase_done_i (erase_done_i),
        .dbg_grant_o  (dbg_grant_o),
        .dbg_viol_o   (dbg_viol_o),
        .locked_o     (locked_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic cold_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic chip_reset();
        chip_rst_i = 1'b1;
        @(negedge clk);
        chip_rst_i = 1'b0;
    endtask

    task automatic lock_write(input logic pb);
        sec_en_wr_i = 1'b1;
        preboot_i   = pb;
        @(negedge clk);
        sec_en_wr_i = 1'b0;
        preboot_i   = 1'b0;
    endtask

    task automatic erase_pulse();
        erase_done_i = 1'b1;
        @(negedge clk);
        erase_done_i = 1'b0;
    endtask

    // Present every code back to back; grant is checked in the cycle, viol one cycle later.
    task automatic sweep(input logic lk);
        for (int c = 0; c < (1 << CMD_W); c++) begin
            logic exp_g;
            exp_g       = !lk || (c == ERASE);
            dbg_valid_i = 1'b1;
            dbg_cmd_i   = CMD_W'(c);
            #1;
            check(lk ? (c == ERASE ? "R4 grant" : "R5 grant") : "R6 grant", dbg_grant_o, exp_g);
            @(negedge clk);
            check(lk ? "R5 viol" : "R6 viol", dbg_viol_o, !exp_g);
        end
        dbg_valid_i = 1'b0;
        @(negedge clk);
        check("R5 viol one cycle", dbg_viol_o, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        report();
    end

    initial begin
        @(negedge clk);
        cold_reset();
        check("R1 lock after reset", locked_o, 1'b0);
        check("R1 viol after reset", dbg_viol_o, 1'b0);
        sweep(1'b0);

        lock_write(1'b0);
        check("R3 write outside preboot", locked_o, 1'b0);
        sweep(1'b0);

        lock_write(1'b1);
        check("R2 write in preboot", locked_o, 1'b1);
        sweep(1'b1);

        chip_reset();
        check("R7 reset without erase", locked_o, 1'b1);

        erase_pulse();
        check("R8 erase alone keeps lock", locked_o, 1'b1);
        @(negedge clk);
        chip_reset();
        check("R8 erase then reset unlocks", locked_o, 1'b0);
        sweep(1'b0);

        lock_write(1'b1);
        chip_reset();
        check("R9 flag consumed by reset", locked_o, 1'b1);

        erase_done_i = 1'b1;
        chip_reset();
        erase_done_i = 1'b0;
        check("R10 same-cycle erase", locked_o, 1'b1);
        chip_reset();
        check("R10 erase not recorded", locked_o, 1'b1);

        erase_pulse();
        lock_write(1'b1);
        chip_reset();
        check("R11 lock write drops erase", locked_o, 1'b1);
        erase_pulse();
        chip_reset();
        check("R11 later erase unlocks", locked_o, 1'b0);

        sec_en_wr_i = 1'b1;
        preboot_i   = 1'b1;
        chip_reset();
        sec_en_wr_i = 1'b0;
        preboot_i   = 1'b0;
        check("R12 write during chip reset", locked_o, 1'b0);

        lock_write(1'b1);
        check("R2 relock", locked_o, 1'b1);
        sweep(1'b1);
        cold_reset();
        check("R1 power-on reset opens", locked_o, 1'b0);
        check("R1 viol cleared", dbg_viol_o, 1'b0);

        report();
    end

endmodule